// File: doc/BRIEF.md
# Programmable External Bus Cycle Timer

This block times the strobes of one external memory region during a single read or write bus cycle. It runs with a fixed wait: there is no handshake and no DRAM sequencing. A 16-bit timing word sets each edge of the cycle in memory-clock counts. The fields are the cycle start delay, the strobe assert delay, how long the address stays valid, the strobe negate point and the cycle end.

A host raises `req_i` with the direction flag and the timing word. On the accepting edge the block latches the word and the direction. It then drives chip select, address-valid and one of the read or write strobes, and pulses `done_o` when the end count is reached.

The word is checked against ordering rules and against a start-delay limit that depends on the memory-clock to system-clock ratio. A bad word does not stop the cycle. It sets a sticky error flag, and the block runs with values clamped to safe limits.

Top module: `ext_bus_timer`

## Requirements
- R1: Count k is 0 in the first cycle after the edge that accepts a request and rises by 1 each cycle. Timing word bits [1:0] give the start delay S. Chip select `cs_o` is high for S <= k < E.
- R2: Timing word bits [3:2] give the strobe delay W, and bits [15:11] give the negate count N. The selected strobe is high for S+W <= k < N while chip select is high. It is the read strobe if `rd_nwr_i` was 1 at acceptance, otherwise the write strobe. The two strobes are never high together.
- R3: The write strobe negates at the same count N as the read strobe.
- R4: Timing word bits [5:4] give the address hold A. `addr_valid_o` is high for S <= k <= S+A while chip select is high.
- R5: Timing word bits [10:6] give the end count E. `done_o` is high for exactly one cycle, at k = E. In the next cycle `busy_o` is low.
- R6: `config_error_o` is set by accepting a word for which any of these holds: E < 4, N < 4, E < N, E < S+A, or S is above the ratio limit. The flag then stays set until reset.
- R7: The cycle runs with E and N raised to at least 4. S is lowered to the limit set by `clk_ratio_i`: 1 allows 0, 2 allows up to 1, and any other value allows up to 3.
- R8: A request made while `busy_o` is high is ignored. Changes to the timing word, ratio or direction after acceptance have no effect on the running cycle.
- R9: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request a bus cycle |
| rd_nwr_i | input | 1 | 1 = read, 0 = write |
| timing_word_i | input | 16 | Timing fields of the cycle |
| clk_ratio_i | input | 2 | Memory-clock to system-clock ratio |
| cs_o | output | 1 | Chip select |
| addr_valid_o | output | 1 | Address output valid |
| rd_strobe_o | output | 1 | Read strobe |
| wr_strobe_o | output | 1 | Write strobe |
| done_o | output | 1 | End-of-cycle pulse |
| busy_o | output | 1 | Cycle in progress |
| config_error_o | output | 1 | Sticky bad-setting flag |

## Verification
The end of a cycle and the acceptance of a new request can fall on the same clock edge. The bench provokes this by holding `req_i` high across the `done_o` cycle. It then checks that `busy_o` drops for exactly one cycle before the next cycle starts, with chip select timed afresh from the new count zero. A second collision is a request raised in the middle of a cycle with a shorter timing word. The bench judges it by `done_o` still arriving at the first cycle's end count.

// File: rtl/ext_bus_timer_pkg.sv
package ext_bus_timer_pkg;
  localparam int CNT_W = 5;
  localparam int DLY_W = 2;
  localparam int MIN_CNT = 4;

  typedef struct packed {
    logic [CNT_W-1:0] neg_cnt;
    logic [CNT_W-1:0] end_cnt;
    logic [DLY_W-1:0] addr_hold;
    logic [DLY_W-1:0] strb_dly;
    logic [DLY_W-1:0] start_dly;
  } timing_t;
endpackage

// File: rtl/ebt_cfg_decode.sv
module ebt_cfg_decode
  import ext_bus_timer_pkg::*;
#(
  parameter int WORD_W = 2*CNT_W + 3*DLY_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [1:0]        ratio_i,
  output timing_t           cfg_o,
  output logic              bad_o
);
  localparam int EXT_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] MINV = CNT_W'(MIN_CNT);

  timing_t          raw;
  logic [DLY_W-1:0] lim;
  logic [EXT_W-1:0] s_plus_a;

  assign raw = timing_t'(word_i);

  always_comb begin
    case (ratio_i)
      2'd1:    lim = DLY_W'(0);
      2'd2:    lim = DLY_W'(1);
      default: lim = {DLY_W{1'b1}};
    endcase
  end

  assign s_plus_a = EXT_W'(raw.start_dly) + EXT_W'(raw.addr_hold);

  always_comb begin
    cfg_o           = raw;
    cfg_o.start_dly = (raw.start_dly > lim) ? lim : raw.start_dly;
    cfg_o.end_cnt   = (raw.end_cnt < MINV) ? MINV : raw.end_cnt;
    cfg_o.neg_cnt   = (raw.neg_cnt < MINV) ? MINV : raw.neg_cnt;
  end

  assign bad_o = (raw.end_cnt < MINV) || (raw.neg_cnt < MINV) ||
                 (raw.end_cnt < raw.neg_cnt) ||
                 (EXT_W'(raw.end_cnt) < s_plus_a) ||
                 (raw.start_dly > lim);
endmodule

// File: rtl/ebt_cycle_seq.sv
module ebt_cycle_seq
  import ext_bus_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             dir_i,
  input  timing_t          cfg_i,
  input  logic             bad_i,
  output logic             act_nxt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output timing_t          cfg_nxt_o,
  output logic             dir_nxt_o,
  output logic             busy_o,
  output logic             err_o
);
  logic             busy_q, dir_q, err_q, accept;
  logic [CNT_W-1:0] cnt_q;
  timing_t          cfg_q;

  assign accept = req_i && !busy_q;

  always_comb begin
    act_nxt_o = busy_q;
    cnt_nxt_o = cnt_q;
    cfg_nxt_o = cfg_q;
    dir_nxt_o = dir_q;
    if (accept) begin
      act_nxt_o = 1'b1;
      cnt_nxt_o = '0;
      cfg_nxt_o = cfg_i;
      dir_nxt_o = dir_i;
    end else if (busy_q) begin
      if (cnt_q == cfg_q.end_cnt) begin
        act_nxt_o = 1'b0;
        cnt_nxt_o = '0;
      end else begin
        cnt_nxt_o = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cfg_q  <= '0;
      dir_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= act_nxt_o;
      cnt_q  <= cnt_nxt_o;
      cfg_q  <= cfg_nxt_o;
      dir_q  <= dir_nxt_o;
      err_q  <= err_q | (accept & bad_i);
    end
  end

  assign busy_o = busy_q;
  assign err_o  = err_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != cfg_q.end_cnt) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q); // R6
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(cfg_q)); // R8
endmodule

// File: rtl/ebt_strobe_gen.sv
module ebt_strobe_gen
  import ext_bus_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             act_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  timing_t          cfg_i,
  input  logic             dir_i,
  output logic             cs_o,
  output logic             adv_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             done_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] k, s, sw, sa, e, n;
  logic             cs_n, str_n;

  assign k  = EXT_W'(cnt_i);
  assign s  = EXT_W'(cfg_i.start_dly);
  assign sw = s + EXT_W'(cfg_i.strb_dly);
  assign sa = s + EXT_W'(cfg_i.addr_hold);
  assign e  = EXT_W'(cfg_i.end_cnt);
  assign n  = EXT_W'(cfg_i.neg_cnt);

  assign cs_n  = act_i && (k >= s) && (k < e);
  assign str_n = cs_n && (k >= sw) && (k < n);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_o   <= 1'b0;
      adv_o  <= 1'b0;
      rd_o   <= 1'b0;
      wr_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      cs_o   <= cs_n;
      adv_o  <= cs_n && (k <= sa);
      rd_o   <= str_n && dir_i;
      wr_o   <= str_n && !dir_i;
      done_o <= act_i && (k == e);
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(rd_o && wr_o)); // R2
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
    (rd_o || wr_o) |-> cs_o); // R2
  AST_ADDR_IN_CS: assert property (@(posedge clk) disable iff (rst)
    adv_o |-> cs_o); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R5
endmodule

// File: rtl/ext_bus_timer.sv
module ext_bus_timer
  import ext_bus_timer_pkg::*;
#(
  parameter int WORD_W = 2*CNT_W + 3*DLY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              rd_nwr_i,
  input  logic [WORD_W-1:0] timing_word_i,
  input  logic [1:0]        clk_ratio_i,
  output logic              cs_o,
  output logic              addr_valid_o,
  output logic              rd_strobe_o,
  output logic              wr_strobe_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              config_error_o
);
  timing_t          dec_cfg, cfg_nxt;
  logic             dec_bad, act_nxt, dir_nxt;
  logic [CNT_W-1:0] cnt_nxt;

  ebt_cfg_decode #(.WORD_W(WORD_W)) u_dec (
    .word_i (timing_word_i),
    .ratio_i(clk_ratio_i),
    .cfg_o  (dec_cfg),
    .bad_o  (dec_bad)
  );

  ebt_cycle_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req_i),
    .dir_i    (rd_nwr_i),
    .cfg_i    (dec_cfg),
    .bad_i    (dec_bad),
    .act_nxt_o(act_nxt),
    .cnt_nxt_o(cnt_nxt),
    .cfg_nxt_o(cfg_nxt),
    .dir_nxt_o(dir_nxt),
    .busy_o   (busy_o),
    .err_o    (config_error_o)
  );

  ebt_strobe_gen u_gen (
    .clk   (clk),
    .rst   (rst),
    .act_i (act_nxt),
    .cnt_i (cnt_nxt),
    .cfg_i (cfg_nxt),
    .dir_i (dir_nxt),
    .cs_o  (cs_o),
    .adv_o (addr_valid_o),
    .rd_o  (rd_strobe_o),
    .wr_o  (wr_strobe_o),
    .done_o(done_o)
  );

  AST_CS_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cs_o || done_o) |-> busy_o); // R1
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !busy_o); // R5
endmodule

// File: tb/ext_bus_timer_bench.sv
module ext_bus_timer_bench;
  logic        clk = 1'b0;
  logic        rst, req, dir;
  logic [15:0] word;
  logic [1:0]  ratio;
  logic        cs, adv, rd, wr, done, busy, err;
  int          n_checks = 0, n_errs = 0;
  bit          exp_err = 0;

  always #5 clk = ~clk;

  ext_bus_timer u_ext_bus_timer (
    .clk(clk), .rst(rst), .req_i(req), .rd_nwr_i(dir), .timing_word_i(word),
    .clk_ratio_i(ratio), .cs_o(cs), .addr_valid_o(adv), .rd_strobe_o(rd),
    .wr_strobe_o(wr), .done_o(done), .busy_o(busy), .config_error_o(err));

  // {dir, ratio, N, E, A, W, S}
  localparam int NV = 9;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 2'd3, 5'd8,  5'd12, 2'd1, 2'd1, 2'd2},
    {1'b0, 2'd3, 5'd4,  5'd4,  2'd0, 2'd0, 2'd0},
    {1'b1, 2'd2, 5'd31, 5'd31, 2'd3, 2'd3, 2'd1},
    {1'b0, 2'd1, 5'd5,  5'd9,  2'd2, 2'd2, 2'd0},
    {1'b1, 2'd0, 5'd6,  5'd6,  2'd3, 2'd0, 2'd3},
    {1'b0, 2'd3, 5'd10, 5'd8,  2'd0, 2'd1, 2'd1},
    {1'b1, 2'd1, 5'd6,  5'd10, 2'd0, 2'd0, 2'd2},
    {1'b1, 2'd3, 5'd4,  5'd2,  2'd0, 2'd0, 2'd0},
    {1'b0, 2'd3, 5'd5,  5'd7,  2'd1, 2'd1, 2'd1}
  };

  task automatic check(input bit ok, input string req_tag, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req_tag, what, act, expv);
    end
  endtask

  // Runs one cycle from acceptance and compares every cycle against the model.
  task automatic run_cycle(input logic [18:0] v, input string tag);
    int s, w, a, e, n, lim, bad_k;
    bit d, bad;
    logic [4:0] act_v, exp_v;
    d = v[18];
    s = int'(v[1:0]); w = int'(v[3:2]); a = int'(v[5:4]);
    e = int'(v[10:6]); n = int'(v[15:11]);
    lim = (v[17:16] == 2'd1) ? 0 : (v[17:16] == 2'd2) ? 1 : 3;
    if (e < 4 || n < 4 || e < n || e < s + a || s > lim) exp_err = 1;   // R6
    if (s > lim) s = lim;                                              // R7
    if (e < 4) e = 4;
    if (n < 4) n = 4;
    @(negedge clk);
    req = 1'b1; dir = d; ratio = v[17:16]; word = v[15:0];
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; word = ~word; dir = ~dir; ratio = 2'd1;                // R8
    bad = 0; bad_k = -1; act_v = '0; exp_v = '0;
    for (int k = 0; k <= e; k++) begin
      logic ec, ea, es;
      logic [4:0] got, want;
      ec = (k >= s) && (k < e);
      ea = ec && (k <= s + a);
      es = ec && (k >= s + w) && (k < n);
      want = {ec, ea, es & d, es & ~d, k == e};
      got  = {cs, adv, rd, wr, done};
      if (got !== want || busy !== 1'b1) begin
        if (!bad) begin bad_k = k; act_v = got; exp_v = want; end
        bad = 1;
      end
      @(negedge clk);
    end
    // R1 R2 R3 R4 R5 R7 R8: {cs,adv,rd,wr,done} per count
    check(!bad, tag, $sformatf("timing at k=%0d", bad_k), int'(act_v), int'(exp_v));
    check(busy === 1'b0 && done === 1'b0, "R5", "idle after done",
          int'({busy, done}), 0);
    check(err === exp_err, "R6", "config_error", int'(err), int'(exp_err));
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; req = 1'b0; dir = 1'b0; word = '0; ratio = 2'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({cs, adv, rd, wr, done, busy, err} === 7'b0, "R9", "reset outputs",
          int'({cs, adv, rd, wr, done, busy, err}), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) run_cycle(VEC[i], "R1");

    // R6: reset clears the sticky flag
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; exp_err = 0;
    check(err === 1'b0, "R6", "error cleared by reset", int'(err), 0);

    // R8: mid-cycle request with a short word is ignored
    begin
      int cyc, done_at, dones;
      @(negedge clk);
      req = 1'b1; dir = 1'b1; ratio = 2'd3;
      word = {5'd6, 5'd10, 2'd0, 2'd0, 2'd0};
      @(posedge clk); @(negedge clk); req = 1'b0;
      done_at = -1; dones = 0;
      for (cyc = 0; cyc < 16; cyc++) begin
        if (cyc == 3) begin req = 1'b1; word = {5'd4, 5'd4, 2'd0, 2'd0, 2'd0}; end
        if (cyc == 5) req = 1'b0;
        if (done) begin dones++; if (done_at < 0) done_at = cyc; end
        @(negedge clk);
      end
      check(done_at == 10 && dones == 1, "R8", "done count of busy request",
            done_at, 10);
    end

    // R5: request held high across done gives one idle cycle, then a new cycle
    begin
      bit saw_idle;
      @(negedge clk);
      req = 1'b1; dir = 1'b0; ratio = 2'd3;
      word = {5'd4, 5'd5, 2'd0, 2'd0, 2'd1};
      @(posedge clk); @(negedge clk);
      while (!done) @(negedge clk);
      @(negedge clk);
      saw_idle = (busy === 1'b0) && (cs === 1'b0);
      check(saw_idle, "R5", "idle gap after done", int'(busy), 0);
      @(negedge clk);
      check(busy === 1'b1 && cs === 1'b0, "R1", "new cycle k=0 with S=1",
            int'({busy, cs}), 2);
      @(negedge clk);
      req = 1'b0;
      check(cs === 1'b1 && wr === 1'b1, "R3", "write strobe at k=1",
            int'({cs, wr}), 3);
    end

    repeat (8) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule